// File: doc/BRIEF.md
# Parallel Flash Command Sequence Decoder

This block is the command interpreter on the device side of a byte-wide parallel NOR-style flash model. Every bus write reaches it as a one-cycle beat with a 20-bit address and an 8-bit data byte. The block follows the unlock-protected handshakes that guard programming and erasing. When a handshake completes, it emits a single start pulse with the operation kind and the target address and data, trimmed to the granularity of that operation. An operation engine outside the block carries out the work and reports through a busy input.

The block also has an identification mode. In this mode, reads of the two lowest addresses return a manufacturer byte and a device byte in place of array data. A dedicated one-write command leaves this mode. The same command also clears any handshake that is partly entered. While the engine is busy, every write is dropped without effect, so an internal operation cannot be disturbed by further commands.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After synchronous reset, `id_mode` and `op_start` are 0, `op_kind`, `op_addr` and `op_data` are zero, and the decoder waits for the first unlock write.
- R2: The writes AAh@AAAh, 55h@555h and A0h@AAAh, followed by any fourth write, raise `op_start` for one cycle. The pulse appears in the cycle after the fourth write, with `op_kind`=0 (program), `op_addr` equal to the full 20-bit address of the fourth write and `op_data` equal to its data. The fourth write is always taken as the target, even when its data is F0h.
- R3: Command cycles compare only address bits 14..0, so address bits 19..15 of an unlock or command write may hold any value.
- R4: The erase prefix is AAh@AAAh, 55h@555h, 80h@AAAh, AAh@AAAh, 55h@555h. A sixth write of 50h at any address gives `op_kind`=1 (sector erase), with `op_addr` equal to that address with bits 11..0 cleared.
- R5: After the erase prefix, a sixth write of 30h at any address gives `op_kind`=2 (block erase), with `op_addr` equal to that address with bits 15..0 cleared.
- R6: After the erase prefix, a sixth write of 10h at AAAh gives `op_kind`=3 (chip erase) with `op_addr`=0. 10h at any other address aborts the sequence with no pulse.
- R7: AAh@AAAh, 55h@555h, 90h@AAAh sets `id_mode`. While `id_mode` is 1, a read with address bits 19..1 zero returns BFh when bit 0 is 0 and D8h when bit 0 is 1. Every other read returns `rd_array_data`.
- R8: A write of F0h at any address clears `id_mode` and any partly entered sequence, except when it is the target write of a program sequence.
- R9: A write that does not match the next expected step returns the decoder to idle. The sequence must then start again from AAh@AAAh.
- R10: While `op_busy` is 1, writes have no effect: no pulse, no change to `id_mode`, and no change to the sequence position.
- R11: Each completed sequence gives exactly one single-cycle `op_start`. `op_kind`, `op_addr` and `op_data` hold their values until the next pulse.
- R12: `wr_ready` is always 1. The decoder never applies back-pressure, and a write beat is taken whenever `wr_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | Bus write beat present |
| wr_ready | output | 1 | Always high; beats are never stalled |
| wr_addr | input | 20 | Write address |
| wr_data | input | 8 | Write data |
| op_busy | input | 1 | Operation engine busy; writes are dropped |
| rd_addr | input | 20 | Read address |
| rd_array_data | input | 8 | Byte read from the storage array |
| rd_data | output | 8 | Read result, ID byte or array byte |
| id_mode | output | 1 | Identification mode active |
| op_start | output | 1 | One-cycle start of an operation |
| op_kind | output | 2 | 0 program, 1 sector, 2 block, 3 chip erase |
| op_addr | output | 20 | Target address, trimmed to operation granularity |
| op_data | output | 8 | Data byte of the final write |

## Verification
The bench builds the decoder with its default parameters: a 20-bit address, a 15-bit command compare, 4 KB sectors and 64 KB blocks. With these values, high address bits that the compare ignores can be set to nonzero values during unlock cycles. Sector and block trimming are visible in nibble-aligned hex, and the ID bytes can be compared directly. The program target can be any address, so the bench also places a target write whose data is F0h, which collides with the exit command.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [1:0] {
    OP_PROG = 2'd0,
    OP_SECT = 2'd1,
    OP_BLK  = 2'd2,
    OP_CHIP = 2'd3
  } op_kind_e;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_UNLK1,
    SQ_UNLK2,
    SQ_PGM_TGT,
    SQ_ERS3,
    SQ_ERS4,
    SQ_ERS5
  } seq_state_e;

  typedef struct packed {
    logic at_hi;   // compare bits equal AAAh
    logic at_lo;   // compare bits equal 555h
    logic d_aa;
    logic d_55;
    logic d_a0;
    logic d_80;
    logic d_90;
    logic d_10;
    logic d_50;
    logic d_30;
    logic d_f0;
  } wr_class_t;

  localparam logic [7:0] CODE_KEY1    = 8'hAA;
  localparam logic [7:0] CODE_KEY2    = 8'h55;
  localparam logic [7:0] CODE_PROG    = 8'hA0;
  localparam logic [7:0] CODE_ERSPRE  = 8'h80;
  localparam logic [7:0] CODE_IDIN    = 8'h90;
  localparam logic [7:0] CODE_CHIP    = 8'h10;
  localparam logic [7:0] CODE_SECT    = 8'h50;
  localparam logic [7:0] CODE_BLK     = 8'h30;
  localparam logic [7:0] CODE_RESET   = 8'hF0;
  localparam logic [11:0] ADDR_KEY_HI = 12'hAAA;
  localparam logic [11:0] ADDR_KEY_LO = 12'h555;

endpackage

// File: rtl/flash_cmd_classify.sv
module flash_cmd_classify
  import flash_cmd_pkg::*;
#(
  parameter int unsigned CMP_W = 15
) (
  input  logic [CMP_W-1:0] cmp_addr,
  input  logic [7:0]       data,
  output wr_class_t        cls
);

  localparam logic [CMP_W-1:0] KEY_HI = CMP_W'(ADDR_KEY_HI);
  localparam logic [CMP_W-1:0] KEY_LO = CMP_W'(ADDR_KEY_LO);

  always_comb begin
    cls.at_hi = (cmp_addr == KEY_HI);
    cls.at_lo = (cmp_addr == KEY_LO);
    cls.d_aa  = (data == CODE_KEY1);
    cls.d_55  = (data == CODE_KEY2);
    cls.d_a0  = (data == CODE_PROG);
    cls.d_80  = (data == CODE_ERSPRE);
    cls.d_90  = (data == CODE_IDIN);
    cls.d_10  = (data == CODE_CHIP);
    cls.d_50  = (data == CODE_SECT);
    cls.d_30  = (data == CODE_BLK);
    cls.d_f0  = (data == CODE_RESET);
  end

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_cmd_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      accept,
  input  wr_class_t cls,
  output logic      fire,
  output op_kind_e  fire_kind,
  output logic      id_mode,
  output logic      pgm_pend
);

  seq_state_e state_q, state_d;
  logic       id_set, id_clr;
  logic       key1, key2;

  assign key1     = cls.at_hi && cls.d_aa;
  assign key2     = cls.at_lo && cls.d_55;
  assign pgm_pend = (state_q == SQ_PGM_TGT);

  always_comb begin
    state_d   = state_q;
    fire      = 1'b0;
    fire_kind = OP_PROG;
    id_set    = 1'b0;
    id_clr    = 1'b0;
    if (accept) begin
      state_d = SQ_IDLE;
      unique case (state_q)
        SQ_IDLE:  if (key1) state_d = SQ_UNLK1;
        SQ_UNLK1: if (key2) state_d = SQ_UNLK2;
        SQ_UNLK2: begin
          if (cls.at_hi && cls.d_a0)      state_d = SQ_PGM_TGT;
          else if (cls.at_hi && cls.d_80) state_d = SQ_ERS3;
          else if (cls.at_hi && cls.d_90) id_set  = 1'b1;
        end
        SQ_PGM_TGT: begin
          fire      = 1'b1;
          fire_kind = OP_PROG;
        end
        SQ_ERS3:  if (key1) state_d = SQ_ERS4;
        SQ_ERS4:  if (key2) state_d = SQ_ERS5;
        SQ_ERS5: begin
          if (cls.at_hi && cls.d_10) begin
            fire      = 1'b1;
            fire_kind = OP_CHIP;
          end else if (cls.d_50) begin
            fire      = 1'b1;
            fire_kind = OP_SECT;
          end else if (cls.d_30) begin
            fire      = 1'b1;
            fire_kind = OP_BLK;
          end
        end
        default: state_d = SQ_IDLE;
      endcase
      if (cls.d_f0 && state_q != SQ_PGM_TGT) begin
        id_clr  = 1'b1;
        state_d = SQ_IDLE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SQ_IDLE;
      id_mode <= 1'b0;
    end else begin
      state_q <= state_d;
      if (id_clr)      id_mode <= 1'b0;
      else if (id_set) id_mode <= 1'b1;
    end
  end

endmodule

// File: rtl/flash_cmd_target.sv
module flash_cmd_target
  import flash_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W   = 20,
  parameter int unsigned SECT_LSB = 12,
  parameter int unsigned BLK_LSB  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  op_kind_e          fire_kind,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic              op_start,
  output op_kind_e          op_kind,
  output logic [ADDR_W-1:0] op_addr,
  output logic [7:0]        op_data
);

  localparam logic [ADDR_W-1:0] ALL_ONES  = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] SECT_KEEP = ALL_ONES << SECT_LSB;
  localparam logic [ADDR_W-1:0] BLK_KEEP  = ALL_ONES << BLK_LSB;

  logic [ADDR_W-1:0] trimmed;

  always_comb begin
    unique case (fire_kind)
      OP_PROG: trimmed = wr_addr;
      OP_SECT: trimmed = wr_addr & SECT_KEEP;
      OP_BLK:  trimmed = wr_addr & BLK_KEEP;
      default: trimmed = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      op_start <= 1'b0;
      op_kind  <= OP_PROG;
      op_addr  <= '0;
      op_data  <= '0;
    end else begin
      op_start <= fire;
      if (fire) begin
        op_kind <= fire_kind;
        op_addr <= trimmed;
        op_data <= wr_data;
      end
    end
  end

endmodule

// File: rtl/flash_id_mux.sv
module flash_id_mux #(
  parameter int unsigned ADDR_W = 20,
  parameter logic [7:0]  MFR_ID = 8'hBF,
  parameter logic [7:0]  DEV_ID = 8'hD8
) (
  input  logic              id_mode,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        rd_array_data,
  output logic [7:0]        rd_data
);

  logic id_hit;

  assign id_hit = id_mode && (rd_addr[ADDR_W-1:1] == '0);

  always_comb begin
    if (id_hit) rd_data = rd_addr[0] ? DEV_ID : MFR_ID;
    else        rd_data = rd_array_data;
  end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W   = 20,
  parameter int unsigned CMP_W    = 15,
  parameter int unsigned SECT_LSB = 12,
  parameter int unsigned BLK_LSB  = 16,
  parameter logic [7:0]  MFR_ID   = 8'hBF,
  parameter logic [7:0]  DEV_ID   = 8'hD8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              op_busy,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        rd_array_data,
  output logic [7:0]        rd_data,
  output logic              id_mode,
  output logic              op_start,
  output logic [1:0]        op_kind,
  output logic [ADDR_W-1:0] op_addr,
  output logic [7:0]        op_data
);

  wr_class_t cls;
  logic      accept;
  logic      fire;
  logic      pgm_pend;
  op_kind_e  fire_kind;
  op_kind_e  kind_q;

  assign wr_ready = 1'b1;
  assign accept   = wr_valid && !op_busy;
  assign op_kind  = kind_q;

  flash_cmd_classify #(.CMP_W(CMP_W)) u_cls (
    .cmp_addr (wr_addr[CMP_W-1:0]),
    .data     (wr_data),
    .cls      (cls)
  );

  flash_cmd_seq u_seq (
    .clk       (clk),
    .rst       (rst),
    .accept    (accept),
    .cls       (cls),
    .fire      (fire),
    .fire_kind (fire_kind),
    .id_mode   (id_mode),
    .pgm_pend  (pgm_pend)
  );

  flash_cmd_target #(
    .ADDR_W   (ADDR_W),
    .SECT_LSB (SECT_LSB),
    .BLK_LSB  (BLK_LSB)
  ) u_tgt (
    .clk       (clk),
    .rst       (rst),
    .fire      (fire),
    .fire_kind (fire_kind),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .op_start  (op_start),
    .op_kind   (kind_q),
    .op_addr   (op_addr),
    .op_data   (op_data)
  );

  flash_id_mux #(
    .ADDR_W (ADDR_W),
    .MFR_ID (MFR_ID),
    .DEV_ID (DEV_ID)
  ) u_id (
    .id_mode       (id_mode),
    .rd_addr       (rd_addr),
    .rd_array_data (rd_array_data),
    .rd_data       (rd_data)
  );

endmodule

// File: rtl/flash_cmd_chk.sv
module flash_cmd_chk #(
  parameter int unsigned ADDR_W   = 20,
  parameter int unsigned SECT_LSB = 12,
  parameter int unsigned BLK_LSB  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_valid,
  input logic [7:0]        wr_data,
  input logic              op_busy,
  input logic              id_mode,
  input logic              pgm_pend,
  input logic              op_start,
  input logic [1:0]        op_kind,
  input logic [ADDR_W-1:0] op_addr,
  input logic [7:0]        op_data
);

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    op_start |=> !op_start);  // R11

  AST_TARGET_HELD: assert property (@(posedge clk) disable iff (rst)
    !op_start |-> ($stable(op_addr) && $stable(op_data) && $stable(op_kind)));  // R11

  AST_BUSY_NO_START: assert property (@(posedge clk) disable iff (rst)
    op_busy |=> !op_start);  // R10

  AST_BUSY_KEEPS_ID: assert property (@(posedge clk) disable iff (rst)
    op_busy |=> $stable(id_mode));  // R10

  AST_SECT_ALIGN: assert property (@(posedge clk) disable iff (rst)
    (op_start && op_kind == 2'd1) |-> (op_addr[SECT_LSB-1:0] == '0));  // R4

  AST_BLK_ALIGN: assert property (@(posedge clk) disable iff (rst)
    (op_start && op_kind == 2'd2) |-> (op_addr[BLK_LSB-1:0] == '0));  // R5

  AST_CHIP_ZERO: assert property (@(posedge clk) disable iff (rst)
    (op_start && op_kind == 2'd3) |-> (op_addr == '0));  // R6

  AST_ID_EXIT: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !op_busy && wr_data == 8'hF0 && !pgm_pend) |=> !id_mode);  // R8

endmodule

bind flash_cmd_decoder flash_cmd_chk #(
  .ADDR_W   (ADDR_W),
  .SECT_LSB (SECT_LSB),
  .BLK_LSB  (BLK_LSB)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .wr_valid (wr_valid),
  .wr_data  (wr_data),
  .op_busy  (op_busy),
  .id_mode  (id_mode),
  .pgm_pend (pgm_pend),
  .op_start (op_start),
  .op_kind  (op_kind),
  .op_addr  (op_addr),
  .op_data  (op_data)
);

// File: tb/flash_cmd_decoder_tb.sv
module flash_cmd_decoder_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [19:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        op_busy = 1'b0;
  logic [19:0] rd_addr = '0;
  logic [7:0]  rd_array_data;
  logic [7:0]  rd_data;
  logic        id_mode;
  logic        op_start;
  logic [1:0]  op_kind;
  logic [19:0] op_addr;
  logic [7:0]  op_data;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  logic [29:0] exp_q[$];

  always #4 clk = ~clk;

  assign rd_array_data = rd_addr[7:0] ^ 8'hC3;

  flash_cmd_decoder u_dut (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .op_busy(op_busy),
    .rd_addr(rd_addr), .rd_array_data(rd_array_data), .rd_data(rd_data),
    .id_mode(id_mode), .op_start(op_start), .op_kind(op_kind),
    .op_addr(op_addr), .op_data(op_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [19:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_addr  = a;
    wr_data  = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic push_exp(input logic [1:0] k, input logic [19:0] a, input logic [7:0] d);
    exp_q.push_back({k, a, d});
  endtask

  task automatic erase_prefix(input logic [19:0] hi);
    wr(hi | 20'h00AAA, 8'hAA);
    wr(hi | 20'h00555, 8'h55);
    wr(hi | 20'h00AAA, 8'h80);
    wr(hi | 20'h00AAA, 8'hAA);
    wr(hi | 20'h00555, 8'h55);
  endtask

  task automatic rd_chk(input string req, input logic [19:0] a, input logic [7:0] exp);
    @(negedge clk);
    rd_addr = a;
    #1;
    chk(req, {24'h0, rd_data}, {24'h0, exp});
  endtask

  // monitor: every start pulse is popped and compared against the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && op_start) begin
        if (exp_q.size() == 0) begin
          total++;
          bad++;
          $display("FAIL R11/R9 unexpected start actual=%h expected=none",
                   {op_kind, op_addr, op_data});
        end else begin
          chk("R2/R4/R5/R6 start target", {2'b0, op_kind, op_addr, op_data},
              {2'b0, exp_q.pop_front()});
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state, R12 ready
    chk("R1 id_mode", {31'h0, id_mode}, 0);
    chk("R1 op_start", {31'h0, op_start}, 0);
    chk("R1 op_addr", {12'h0, op_addr}, 0);
    chk("R1 op_kind/data", {22'h0, op_kind, op_data}, 0);
    chk("R12 wr_ready", {31'h0, wr_ready}, 1);
    rd_chk("R7 normal read", 20'h00001, 8'h01 ^ 8'hC3);

    // R2 program, R3 upper address bits ignored in command cycles
    push_exp(2'd0, 20'h12345, 8'h3C);
    wr(20'hF8AAA, 8'hAA);
    wr(20'h38555, 8'h55);
    wr(20'h50AAA, 8'hA0);
    wr(20'h12345, 8'h3C);

    // R4 sector erase
    push_exp(2'd1, 20'hAB000, 8'h50);
    erase_prefix(20'h00000);
    wr(20'hABCDE, 8'h50);

    // R5 block erase
    push_exp(2'd2, 20'h70000, 8'h30);
    erase_prefix(20'h48000);
    wr(20'h7F123, 8'h30);

    // R6 chip erase
    push_exp(2'd3, 20'h00000, 8'h10);
    erase_prefix(20'h00000);
    wr(20'hF0AAA, 8'h10);

    // R6 chip code at the wrong address aborts; R11 target held
    erase_prefix(20'h00000);
    wr(20'h00123, 8'h10);
    repeat (2) @(negedge clk);
    chk("R11 held kind after abort", {30'h0, op_kind}, 3);
    chk("R11 held data after abort", {24'h0, op_data}, 8'h10);

    // R7 ID entry and ID reads
    wr(20'h00AAA, 8'hAA);
    wr(20'h00555, 8'h55);
    wr(20'h00AAA, 8'h90);
    chk("R7 id_mode set", {31'h0, id_mode}, 1);
    rd_chk("R7 manufacturer byte", 20'h00000, 8'hBF);
    rd_chk("R7 device byte", 20'h00001, 8'hD8);
    rd_chk("R7 upper bits set", 20'h80000, 8'h00 ^ 8'hC3);
    rd_chk("R7 other address", 20'h00012, 8'h12 ^ 8'hC3);

    // R10 exit command ignored while busy
    @(negedge clk);
    op_busy = 1'b1;
    wr(20'h00000, 8'hF0);
    chk("R10 id_mode kept while busy", {31'h0, id_mode}, 1);
    op_busy = 1'b0;

    // R10 sequence position kept across a dropped write
    push_exp(2'd0, 20'h0F00F, 8'h99);
    wr(20'h00AAA, 8'hAA);
    wr(20'h00555, 8'h55);
    op_busy = 1'b1;
    wr(20'h00123, 8'h77);
    op_busy = 1'b0;
    wr(20'h00AAA, 8'hA0);
    wr(20'h0F00F, 8'h99);

    // R8 exit at any address
    wr(20'h54321, 8'hF0);
    chk("R8 id_mode cleared", {31'h0, id_mode}, 0);
    rd_chk("R8 array read after exit", 20'h00000, 8'hC3);

    // R8 F0 resets a partial sequence
    wr(20'h00AAA, 8'hAA);
    wr(20'h00555, 8'h55);
    wr(20'h00AAA, 8'hF0);
    wr(20'h00AAA, 8'hA0);
    wr(20'h00100, 8'h11);

    // R2/R8 F0 as program target data is programmed
    push_exp(2'd0, 20'h00200, 8'hF0);
    wr(20'h00AAA, 8'hAA);
    wr(20'h00555, 8'h55);
    wr(20'h00AAA, 8'hA0);
    wr(20'h00200, 8'hF0);

    // R9 mismatch aborts: a wrong third step, then a wrong fifth erase step
    wr(20'h00AAA, 8'hAA);
    wr(20'h00555, 8'h55);
    wr(20'h00AAA, 8'h12);
    wr(20'h00AAA, 8'hA0);
    wr(20'h00300, 8'h22);
    wr(20'h00AAA, 8'hAA);
    wr(20'h00555, 8'h55);
    wr(20'h00AAA, 8'h80);
    wr(20'h00AAA, 8'hAA);
    wr(20'h00556, 8'h55);
    wr(20'h12345, 8'h50);
    repeat (3) @(negedge clk);
    chk("R9 no start after aborts, target held", {12'h0, op_addr}, 32'h00200);
    chk("R11 scoreboard drained", exp_q.size(), 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule